// File: doc/BRIEF.md
# SPI Slave Shift Engine with Select Framing

This block is the receive and transmit shift engine of an SPI slave. It moves one word (eight bits by default) in each direction per frame, most significant bit first. The active-low select input frames every word. The clock-phase control decides whether each word needs its own select pulse or whether words can run back to back under one select. The clock-polarity control sets the idle level of the serial clock.

The serial clock, the select and the MOSI pins arrive asynchronously. They pass through a multi-flop synchroniser, and clock edges are detected in the system clock domain afterwards. The serial clock therefore has to be several times slower than the system clock. For each word, the engine takes a transmit word from its load port and acknowledges it with a one-cycle strobe. A received word is presented with a one-cycle valid strobe. Raising select at any point tri-states MISO and throws away a partly shifted word.

Top module: `spis_slave_frame`

## Requirements
- R1: After reset, `miso_oe_o`, `miso_o`, `rx_valid_o` and `tx_take_o` are all 0.
- R2: While select (`sel_n_i`) is high, `miso_oe_o` is 0 and `miso_o` is held at 0. While select is low, `miso_oe_o` is 1.
- R3: With `cpha_i`=0, a falling edge on select loads `tx_data_i`, pulses `tx_take_o` once, and puts the word's MSB on `miso_o` before the first serial clock edge.
- R4: With `cpha_i`=0, MOSI is sampled on the leading clock edge and MISO advances on the trailing edge, MSB first. The eight sampled bits form `rx_data_o`, and the bits seen on MISO equal the loaded transmit word.
- R5: With `cpha_i`=0, once a word has completed, further clock edges produce no valid strobe and no transmit load until select has gone high and low again.
- R6: With `cpha_i`=1, the first leading edge of each word loads `tx_data_i` (one `tx_take_o` pulse) and drives its MSB. Later leading edges advance MISO, and MOSI is sampled on trailing edges.
- R7: With `cpha_i`=1, select may stay low across several words. Each word gets its own transmit load, and each delivers its own received word.
- R8: `rx_valid_o` is a single-cycle pulse, raised once per completed word, with `rx_data_o` holding that word in the same cycle.
- R9: Select rising mid-word discards the partial word with no valid strobe. The next select-low period starts a fresh word from bit zero.
- R10: Serial clock edges while select is high change nothing: no valid strobe, no transmit load, and the next framed word is intact.
- R11: The leading edge is the transition away from the idle level given by `cpol_i` (0: rising is leading, 1: falling is leading).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| cpol_i | input | 1 | Serial clock idle level; change only while deselected |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| tx_data_i | input | DATA_W | Word to transmit next |
| tx_take_o | output | 1 | One-cycle strobe: `tx_data_i` was loaded |
| miso_o | output | 1 | Serial data to the master (0 when not enabled) |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| rx_data_o | output | DATA_W | Last word received |
| rx_valid_o | output | 1 | One-cycle strobe: `rx_data_o` is new |

## Verification
The bench sweeps all four polarity/phase combinations with varied data patterns and compares every MISO bit and every received word with the pattern it drove. If the sample and shift edges were swapped, or the leading edge were decoded against the wrong idle level, bits would land shifted by one position. Dedicated cases cover the following:
- Select is raised after four bits. A design that kept its bit count would misalign the next word or emit a bogus strobe.
- Clocks are toggled while deselected. A design that did not gate them would corrupt the count.
- Phase-0 clocking continues past a completed word. A design without the completion hold would deliver a second word.
- Phase-1 words run back to back. A design that reloaded only on select would repeat the first transmit word.

// File: rtl/spis_pkg.sv
package spis_pkg;

   // Decoded serial clock events in the system clock domain.
   typedef struct packed {
      logic lead;    // transition away from idle level
      logic trail;   // transition back to idle level
   } sclk_evt_t;

   // Framing events derived from the synchronised select.
   typedef struct packed {
      logic active;  // select asserted
      logic start;   // first cycle of assertion
   } frame_evt_t;

   // Index of the synchronised bundle bits.
   localparam int unsigned BIT_SCLK = 0;
   localparam int unsigned BIT_MOSI = 1;
   localparam int unsigned BIT_SELN = 2;
   localparam int unsigned PIN_COUNT = 3;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int unsigned           WIDTH   = 1,
   parameter int unsigned           STAGES  = 2,
   parameter logic [WIDTH-1:0]      RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spis_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spis_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
module spis_edge
   import spis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk_s_i,
   input  logic       sel_n_s_i,
   input  logic       cpol_i,
   output sclk_evt_t  evt_o,
   output frame_evt_t frm_o
);

   logic sclk_q;
   logic act_q;
   logic act;

   assign act = ~sel_n_s_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         sclk_q <= sclk_s_i;
         act_q  <= act;
      end
   end

   // Edges only count while selected; the rest are dropped here.
   always_comb begin
      evt_o.lead  = act && (sclk_q == cpol_i) && (sclk_s_i != cpol_i);
      evt_o.trail = act && (sclk_q != cpol_i) && (sclk_s_i == cpol_i);
      frm_o.active = act;
      frm_o.start  = act && !act_q;
   end

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_o.lead && evt_o.trail)); // R11

endmodule

// File: rtl/spis_core.sv
module spis_core
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpha_i,
   input  sclk_evt_t         evt_i,
   input  frame_evt_t        frm_i,
   input  logic              mosi_s_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_take_o,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o
);

   localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spis_core: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] tx_sr;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] rx_next;
   logic [CNT_W-1:0]  bit_cnt;
   logic              word_done;
   logic              oe_q;
   logic              last_bit;

   assign rx_next  = {rx_sr[DATA_W-2:0], mosi_s_i};
   assign last_bit = (bit_cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr      <= '0;
         rx_sr      <= '0;
         rx_data_o  <= '0;
         rx_valid_o <= 1'b0;
         tx_take_o  <= 1'b0;
         bit_cnt    <= '0;
         word_done  <= 1'b0;
         oe_q       <= 1'b0;
      end else begin
         rx_valid_o <= 1'b0;
         tx_take_o  <= 1'b0;
         oe_q       <= frm_i.active;
         if (!frm_i.active) begin
            bit_cnt   <= '0;
            word_done <= 1'b0;
         end else if (frm_i.start) begin
            bit_cnt   <= '0;
            word_done <= 1'b0;
            if (!cpha_i) begin
               tx_sr     <= tx_data_i;
               tx_take_o <= 1'b1;
            end else begin
               tx_sr <= '0;
            end
         end else if (!cpha_i) begin
            // Phase 0: sample on leading, advance on trailing.
            if (evt_i.lead && !word_done) begin
               rx_sr <= rx_next;
               if (last_bit) begin
                  rx_data_o  <= rx_next;
                  rx_valid_o <= 1'b1;
                  word_done  <= 1'b1;
                  bit_cnt    <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end else if (evt_i.trail && !word_done && bit_cnt != '0) begin
               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
         end else begin
            // Phase 1: drive on leading, sample on trailing.
            if (evt_i.lead) begin
               if (bit_cnt == '0) begin
                  tx_sr     <= tx_data_i;
                  tx_take_o <= 1'b1;
               end else begin
                  tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
               end
            end else if (evt_i.trail) begin
               rx_sr <= rx_next;
               if (last_bit) begin
                  rx_data_o  <= rx_next;
                  rx_valid_o <= 1'b1;
                  bit_cnt    <= '0;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

   assign miso_oe_o = oe_q;
   assign miso_o    = oe_q & tx_sr[DATA_W-1];

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o); // R8
   AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take_o |=> !tx_take_o); // R3
   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_i.active |=> (!rx_valid_o && !tx_take_o && bit_cnt == '0)); // R9
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_LAST); // R4
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && frm_i.active && !frm_i.start && !cpha_i) |=> !rx_valid_o); // R5

endmodule

// File: rtl/spis_slave_frame.sv
module spis_slave_frame
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              mosi_i,
   input  logic              sel_n_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic              tx_take_o,
   output logic              miso_o,
   output logic              miso_oe_o,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o
);

   localparam logic [PIN_COUNT-1:0] PIN_RST = PIN_COUNT'(1) << BIT_SELN;

   logic [PIN_COUNT-1:0] pins_raw;
   logic [PIN_COUNT-1:0] pins_s;
   sclk_evt_t            evt;
   frame_evt_t           frm;

   always_comb begin
      pins_raw           = '0;
      pins_raw[BIT_SCLK] = sclk_i;
      pins_raw[BIT_MOSI] = mosi_i;
      pins_raw[BIT_SELN] = sel_n_i;
   end

   spis_sync #(
      .WIDTH   (PIN_COUNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   spis_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_s_i  (pins_s[BIT_SCLK]),
      .sel_n_s_i (pins_s[BIT_SELN]),
      .cpol_i    (cpol_i),
      .evt_o     (evt),
      .frm_o     (frm)
   );

   spis_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpha_i     (cpha_i),
      .evt_i      (evt),
      .frm_i      (frm),
      .mosi_s_i   (pins_s[BIT_MOSI]),
      .tx_data_i  (tx_data_i),
      .tx_take_o  (tx_take_o),
      .miso_o     (miso_o),
      .miso_oe_o  (miso_oe_o),
      .rx_data_o  (rx_data_o),
      .rx_valid_o (rx_valid_o)
   );

   AST_TRISTATE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !miso_oe_o |-> !miso_o); // R2
   AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe_o && $past(miso_oe_o)) |-> $past(frm.active)); // R2

endmodule

// File: tb/sim_spis_slave_frame.sv
module sim_spis_slave_frame;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int H          = 6;   // serial half period in system cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0;
   logic          mosi = 1'b0;
   logic          sel_n = 1'b1;
   logic          cpol = 1'b0;
   logic          cpha = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_take;
   logic          miso;
   logic          miso_oe;
   logic [DW-1:0] rx_data;
   logic          rx_valid;

   int n_chk = 0;
   int n_fail = 0;
   int vcount = 0;
   int tcount = 0;
   logic [DW-1:0] last_rx = '0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spis_slave_frame #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .sel_n_i(sel_n),
      .cpol_i(cpol), .cpha_i(cpha), .tx_data_i(tx_data), .tx_take_o(tx_take),
      .miso_o(miso), .miso_oe_o(miso_oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            vcount++;
            last_rx = rx_data;
         end
         if (tx_take) tcount++;
      end
   end

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic run_bits(input logic [DW-1:0] mo, input int nb, output logic [DW-1:0] mi);
      mi = '0;
      for (int i = 0; i < nb; i++) begin
         if (!cpha) begin
            mosi = mo[DW-1-i];
            wait_c(H);
            mi[DW-1-i] = miso;
            sclk = ~cpol;
            wait_c(H);
            sclk = cpol;
         end else begin
            sclk = ~cpol;
            mosi = mo[DW-1-i];
            wait_c(H);
            mi[DW-1-i] = miso;
            sclk = cpol;
            wait_c(H);
         end
      end
      wait_c(H);
   endtask

   task automatic set_mode(input int m);
      cpol = m[1];
      cpha = m[0];
      sclk = m[1];
      wait_c(H);
   endtask

   task automatic select_on();
      sel_n = 1'b0;
      wait_c(H);
   endtask

   task automatic select_off();
      sel_n = 1'b1;
      wait_c(H);
   endtask

   // One framed word: checks received word, MISO bits and strobes.
   task automatic framed_word(input string req, input logic [DW-1:0] mo, input logic [DW-1:0] to);
      int v0;
      int t0;
      logic [DW-1:0] mi;
      v0 = vcount;
      t0 = tcount;
      tx_data = to;
      select_on();
      check("R2", "oe while selected", int'(miso_oe), 1);
      if (!cpha) begin
         check("R3", "take on select fall", tcount - t0, 1);
         check("R3", "MSB before first edge", int'(miso), int'(to[DW-1]));
      end
      run_bits(mo, DW, mi);
      check(req, "rx word", int'(last_rx), int'(mo));
      check(req, "miso word", int'(mi), int'(to));
      check("R8", "valid count", vcount - v0, 1);
      check(cpha ? "R6" : "R3", "take count", tcount - t0, 1);
      select_off();
      check("R2", "oe deselected", int'(miso_oe), 0);
      check("R2", "miso deselected", int'(miso), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      report();
   end

   initial begin
      logic [DW-1:0] mi;
      int v0;
      int t0;
      wait_c(4);
      rst_n = 1'b1;
      wait_c(4);
      check("R1", "oe after reset", int'(miso_oe), 0);
      check("R1", "miso after reset", int'(miso), 0);
      check("R1", "valid after reset", vcount, 0);
      check("R1", "take after reset", tcount, 0);

      // Sweep of all four modes over varied patterns (R4, R6, R11).
      for (int m = 0; m < 4; m++) begin
         set_mode(m);
         for (int k = 0; k < 8; k++) begin
            logic [DW-1:0] pat;
            case (k)
               0: pat = 8'h00;
               1: pat = 8'hFF;
               2: pat = 8'hA5;
               3: pat = 8'h80;
               4: pat = 8'h01;
               default: pat = DW'((k * 73 + m * 29) & 8'hFF);
            endcase
            framed_word(m[0] ? "R6" : "R4", pat, pat ^ DW'((m * 16 + k) * 5 + 8'h96));
            if (m[1]) check("R11", "cpol=1 word", int'(last_rx), int'(pat));
         end
      end

      // R5: phase 0, extra clocks after a complete word do nothing.
      set_mode(0);
      v0 = vcount;
      t0 = tcount;
      tx_data = 8'h3C;
      select_on();
      run_bits(8'hC3, DW, mi);
      run_bits(8'h5A, DW, mi);
      check("R5", "valid count after extra clocks", vcount - v0, 1);
      check("R5", "word kept", int'(last_rx), 8'hC3);
      check("R5", "take count", tcount - t0, 1);
      select_off();
      framed_word("R5", 8'h66, 8'h99);

      // R7: phase 1, three words under one select.
      for (int p = 0; p < 2; p++) begin
         set_mode(p * 2 + 1);
         v0 = vcount;
         t0 = tcount;
         select_on();
         for (int w = 0; w < 3; w++) begin
            logic [DW-1:0] mo;
            logic [DW-1:0] to;
            mo = DW'(8'h1B * (w + 1) + p);
            to = DW'(8'hE4 - 8'h31 * w);
            tx_data = to;
            run_bits(mo, DW, mi);
            check("R7", "b2b rx word", int'(last_rx), int'(mo));
            check("R7", "b2b miso word", int'(mi), int'(to));
            check("R7", "b2b valid count", vcount - v0, w + 1);
         end
         check("R7", "b2b take count", tcount - t0, 3);
         select_off();
      end

      // R9: abort mid-word in every mode, then a clean word.
      for (int m = 0; m < 4; m++) begin
         set_mode(m);
         v0 = vcount;
         tx_data = 8'hF0;
         select_on();
         run_bits(8'hFF, 4, mi);
         select_off();
         check("R9", "no valid after abort", vcount - v0, 0);
         check("R9", "oe low after abort", int'(miso_oe), 0);
         framed_word("R9", 8'h4D, 8'hB2);
      end

      // R10: clocks while deselected are ignored.
      for (int c = 0; c < 2; c++) begin
         set_mode(c);
         v0 = vcount;
         t0 = tcount;
         run_bits(8'hAA, DW, mi);
         check("R10", "no valid deselected", vcount - v0, 0);
         check("R10", "no take deselected", tcount - t0, 0);
         check("R10", "miso quiet", int'(mi), 0);
         framed_word("R10", 8'h17, 8'hE8);
      end

      report();
   end

endmodule